// File: doc/BRIEF.md
# Key-Gated Diagnostic Arming Register

This block is a single 32-bit control word that sits in front of a flash controller's self-test logic. Software first writes an unlock key and a test mode, together with a buffer or port selector. It then sets a write-one trigger bit. The trigger arms the block only when the key matches the unlock value and the mode is one of the two supported tests. The key and mode used for this check are the ones carried by the same write.

Once armed, the block waits for the next access-done pulse from the flash datapath. It answers with a single-cycle diagnostic strobe that carries the active mode and selector, plus one-hot enables for the chosen address-tag buffer or ECC-flip port. After that strobe the armed state is gone, so each trigger covers exactly one access. Only privileged bus writes reach the fields. The trigger bit and all unused bit positions always read back as zero.

Top module: `diag_ctl_top`

## Requirements
- R1: After reset the read value is 0x000A0000 (key field 0xA, select 0, mode 0), the armed flag is low and every decoded output is low.
- R2: A privileged write loads the key from bits 19:16, the selector from bits 10:8 and the mode from bits 2:0. The read value reflects them from the next cycle.
- R3: A write with the privilege qualifier low changes no field and does not arm the block.
- R4: Bits 31:20, 15:11 and 7:3 always read as 0, and this includes the trigger at bit 24.
- R5: A privileged write with bit 24 set arms the block on the next cycle only if that write's own key is 0x5 and its own mode is 5 or 7. Otherwise the trigger is dropped.
- R6: While armed with a qualifying key and mode, an access-done pulse makes `diag_active` high for the next cycle only, with `diag_mode` and `diag_sel` equal to the register mode and selector. The armed flag clears at that same edge.
- R7: During an active strobe in mode 5, selector 0 or 1 raises `tag_sel_a` bit 0 or bit 1. Selector 4 to 7 raises `tag_sel_b` bit (selector − 4). Selectors 2 and 3 raise nothing.
- R8: During an active strobe in mode 7, selector 0 raises `flip_port_a` and selector 4 raises `flip_port_b`. Any other selector raises no select output. Outside an active strobe all decoded outputs are 0.
- R9: If the stored key stops being 0x5, or the stored mode stops being 5 or 7, while the block is armed, the armed flag drops on the following edge and no strobe is produced.
- R10: A qualifying trigger write in the same cycle as a firing access re-arms the block, so the next access fires again.
- R11: An access-done pulse while not armed produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_priv | input | 1 | Privilege qualifier for the write |
| reg_wdata | input | 32 | Write data |
| acc_done | input | 1 | One-cycle pulse from the datapath when an access completes |
| reg_rdata | output | 32 | Read value of the control word |
| diag_armed | output | 1 | A trigger is pending |
| diag_active | output | 1 | One-cycle diagnostic strobe |
| diag_mode | output | 3 | Mode carried by the strobe, 0 otherwise |
| diag_sel | output | 3 | Selector carried by the strobe, 0 otherwise |
| tag_sel_a | output | 2 | One-hot port A tag buffer enable |
| tag_sel_b | output | 4 | One-hot port B tag buffer enable |
| flip_port_a | output | 1 | Flip data/ECC on port A |
| flip_port_b | output | 1 | Flip data/ECC on port B |

## Verification
Two events can land on the same cycle: a trigger write, which sets the armed flag, and an access-done pulse on an armed block, which clears it. The bench forces this overlap directly and then looks at the following cycles to confirm that the strobe fires once and that the block stays armed for a second firing. A related overlap is a field write that invalidates the key while an access is pending. The random phase also keeps writes and access pulses dense so that these overlaps recur. Every cycle is judged against a bench model of the arm/fire/drop rules.

// File: rtl/diag_ctl_pkg.sv
package diag_ctl_pkg;

  localparam int REG_W    = 32;
  localparam int TRIG_BIT = 24;
  localparam int KEY_LSB  = 16;
  localparam int KEY_W    = 4;
  localparam int SEL_LSB  = 8;
  localparam int SEL_W    = 3;
  localparam int MODE_LSB = 0;
  localparam int MODE_W   = 3;

  typedef logic [KEY_W-1:0]  key_t;
  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [MODE_W-1:0] mode_t;

  localparam key_t  KEY_OPEN  = 4'h5;
  localparam key_t  KEY_RESET = 4'hA;
  localparam mode_t MODE_OFF  = 3'd0;
  localparam mode_t MODE_TAG  = 3'd5;
  localparam mode_t MODE_ECC  = 3'd7;

  // Mask of every bit that reads as zero (includes trigger)
  localparam logic [REG_W-1:0] FIELD_MASK =
      (REG_W'((1 << KEY_W) - 1) << KEY_LSB) |
      (REG_W'((1 << SEL_W) - 1) << SEL_LSB) |
      (REG_W'((1 << MODE_W) - 1) << MODE_LSB);
  localparam logic [REG_W-1:0] ZERO_MASK = ~FIELD_MASK;

  typedef struct packed {
    key_t  key;
    sel_t  sel;
    mode_t mode;
  } ctl_fields_t;

  function automatic logic fields_qualify(input key_t k, input mode_t m);
    return (k == KEY_OPEN) && ((m == MODE_TAG) || (m == MODE_ECC));
  endfunction

endpackage

// File: rtl/diag_ctl_regs.sv
module diag_ctl_regs
  import diag_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_priv,
  input  logic [REG_W-1:0] reg_wdata,
  output ctl_fields_t      fields_q,
  output ctl_fields_t      wr_fields,
  output logic             trig_req,
  output logic             wr_ok,
  output logic [REG_W-1:0] rdata
);

  ctl_fields_t fields_d;

  // Field slices of the incoming write
  always_comb begin
    wr_fields.key  = reg_wdata[KEY_LSB  +: KEY_W];
    wr_fields.sel  = reg_wdata[SEL_LSB  +: SEL_W];
    wr_fields.mode = reg_wdata[MODE_LSB +: MODE_W];
  end

  assign wr_ok    = reg_wr & reg_priv;
  assign trig_req = wr_ok & reg_wdata[TRIG_BIT];

  // Next state
  always_comb begin
    fields_d = fields_q;
    if (wr_ok) begin
      fields_d = wr_fields;
    end
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q.key  <= KEY_RESET;
      fields_q.sel  <= '0;
      fields_q.mode <= MODE_OFF;
    end else if (wr_ok) begin
      fields_q <= fields_d;
    end
  end

  // Read view: trigger and unused positions stay zero
  always_comb begin
    rdata = '0;
    rdata[KEY_LSB  +: KEY_W]  = fields_q.key;
    rdata[SEL_LSB  +: SEL_W]  = fields_q.sel;
    rdata[MODE_LSB +: MODE_W] = fields_q.mode;
  end

endmodule

// File: rtl/diag_ctl_arm.sv
module diag_ctl_arm
  import diag_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ctl_fields_t fields_q,
  input  ctl_fields_t wr_fields,
  input  logic        trig_req,
  input  logic        acc_done,
  output logic        armed_q,
  output logic        active_q,
  output mode_t       act_mode_q,
  output sel_t        act_sel_q
);

  logic  qual_now;
  logic  trig_ok;
  logic  fire;
  logic  armed_d;
  logic  active_d;
  mode_t act_mode_d;
  sel_t  act_sel_d;

  // Trigger is judged on the values it writes; firing on stored values
  assign qual_now = fields_qualify(fields_q.key, fields_q.mode);
  assign trig_ok  = trig_req & fields_qualify(wr_fields.key, wr_fields.mode);
  assign fire     = armed_q & acc_done & qual_now;

  // Next state: a new trigger wins over consumption or disqualification
  always_comb begin
    armed_d = armed_q;
    if (trig_ok) begin
      armed_d = 1'b1;
    end else if (fire || !qual_now) begin
      armed_d = 1'b0;
    end
    active_d   = fire;
    act_mode_d = act_mode_q;
    act_sel_d  = act_sel_q;
    if (fire) begin
      act_mode_d = fields_q.mode;
      act_sel_d  = fields_q.sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      active_q <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      active_q <= active_d;
    end
  end

  // Captured strobe payload, enabled only on a firing access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode_q <= MODE_OFF;
      act_sel_q  <= '0;
    end else if (fire) begin
      act_mode_q <= act_mode_d;
      act_sel_q  <= act_sel_d;
    end
  end

endmodule

// File: rtl/diag_ctl_dec.sv
module diag_ctl_dec
  import diag_ctl_pkg::*;
#(
  parameter int PORTA_BUFS = 2,
  parameter int PORTB_BUFS = 4
) (
  input  logic                  active,
  input  mode_t                 mode,
  input  sel_t                  sel,
  output logic [PORTA_BUFS-1:0] tag_sel_a,
  output logic [PORTB_BUFS-1:0] tag_sel_b,
  output logic                  flip_a,
  output logic                  flip_b,
  output mode_t                 mode_o,
  output sel_t                  sel_o
);

  localparam int PORTB_BASE = 1 << (SEL_W - 1);

  logic tag_en;
  logic ecc_en;

  assign tag_en = active && (mode == MODE_TAG);
  assign ecc_en = active && (mode == MODE_ECC);

  for (genvar ia = 0; ia < PORTA_BUFS; ia++) begin : g_tag_a
    assign tag_sel_a[ia] = tag_en && (sel == SEL_W'(ia));
  end

  for (genvar ib = 0; ib < PORTB_BUFS; ib++) begin : g_tag_b
    assign tag_sel_b[ib] = tag_en && (sel == SEL_W'(PORTB_BASE + ib));
  end

  assign flip_a = ecc_en && (sel == SEL_W'(0));
  assign flip_b = ecc_en && (sel == SEL_W'(PORTB_BASE));
  assign mode_o = active ? mode : MODE_OFF;
  assign sel_o  = active ? sel  : '0;

endmodule

// File: rtl/diag_ctl_top.sv
module diag_ctl_top
  import diag_ctl_pkg::*;
#(
  parameter int PORTA_BUFS = 2,
  parameter int PORTB_BUFS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_priv,
  input  logic [31:0]           reg_wdata,
  input  logic                  acc_done,
  output logic [31:0]           reg_rdata,
  output logic                  diag_armed,
  output logic                  diag_active,
  output logic [2:0]            diag_mode,
  output logic [2:0]            diag_sel,
  output logic [PORTA_BUFS-1:0] tag_sel_a,
  output logic [PORTB_BUFS-1:0] tag_sel_b,
  output logic                  flip_port_a,
  output logic                  flip_port_b
);

  ctl_fields_t fields_q;
  ctl_fields_t wr_fields;
  logic        trig_req;
  logic        wr_ok;
  mode_t       act_mode_q;
  sel_t        act_sel_q;
  logic        active_q;

  diag_ctl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_priv  (reg_priv),
    .reg_wdata (reg_wdata),
    .fields_q  (fields_q),
    .wr_fields (wr_fields),
    .trig_req  (trig_req),
    .wr_ok     (wr_ok),
    .rdata     (reg_rdata)
  );

  diag_ctl_arm u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fields_q   (fields_q),
    .wr_fields  (wr_fields),
    .trig_req   (trig_req),
    .acc_done   (acc_done),
    .armed_q    (diag_armed),
    .active_q   (active_q),
    .act_mode_q (act_mode_q),
    .act_sel_q  (act_sel_q)
  );

  diag_ctl_dec #(
    .PORTA_BUFS (PORTA_BUFS),
    .PORTB_BUFS (PORTB_BUFS)
  ) u_dec (
    .active    (active_q),
    .mode      (act_mode_q),
    .sel       (act_sel_q),
    .tag_sel_a (tag_sel_a),
    .tag_sel_b (tag_sel_b),
    .flip_a    (flip_port_a),
    .flip_b    (flip_port_b),
    .mode_o    (diag_mode),
    .sel_o     (diag_sel)
  );

  assign diag_active = active_q;

endmodule

// File: rtl/diag_ctl_chk.sv
module diag_ctl_chk
  import diag_ctl_pkg::*;
#(
  parameter int PORTA_BUFS = 2,
  parameter int PORTB_BUFS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic                  reg_priv,
  input logic [31:0]           reg_wdata,
  input logic                  acc_done,
  input logic [31:0]           reg_rdata,
  input logic                  diag_armed,
  input logic                  diag_active,
  input logic [2:0]            diag_mode,
  input logic [2:0]            diag_sel,
  input logic [PORTA_BUFS-1:0] tag_sel_a,
  input logic [PORTB_BUFS-1:0] tag_sel_b,
  input logic                  flip_port_a,
  input logic                  flip_port_b
);

  logic [PORTA_BUFS+PORTB_BUFS+1:0] all_sel;
  assign all_sel = {tag_sel_a, tag_sel_b, flip_port_a, flip_port_b};

  // R4
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ZERO_MASK) == '0);

  // R3
  nonpriv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_priv) |=> $stable(reg_rdata));

  // R5
  arm_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(diag_armed) |->
      (reg_rdata[KEY_LSB +: KEY_W] == KEY_OPEN) &&
      ((reg_rdata[MODE_LSB +: MODE_W] == MODE_TAG) ||
       (reg_rdata[MODE_LSB +: MODE_W] == MODE_ECC)));

  // R6
  active_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diag_active |-> ($past(diag_armed) && $past(acc_done)));

  // R6
  fire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_armed && acc_done && !(reg_wr && reg_priv && reg_wdata[TRIG_BIT]))
      |=> !diag_armed);

  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(all_sel));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_active |-> ((all_sel == '0) && (diag_mode == '0) && (diag_sel == '0)));

  // R11
  idle_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_armed |=> !diag_active);

endmodule

bind diag_ctl_top diag_ctl_chk #(
  .PORTA_BUFS (PORTA_BUFS),
  .PORTB_BUFS (PORTB_BUFS)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_priv    (reg_priv),
  .reg_wdata   (reg_wdata),
  .acc_done    (acc_done),
  .reg_rdata   (reg_rdata),
  .diag_armed  (diag_armed),
  .diag_active (diag_active),
  .diag_mode   (diag_mode),
  .diag_sel    (diag_sel),
  .tag_sel_a   (tag_sel_a),
  .tag_sel_b   (tag_sel_b),
  .flip_port_a (flip_port_a),
  .flip_port_b (flip_port_b)
);

// File: tb/diag_ctl_top_tb_top.sv
module diag_ctl_top_tb_top;

  localparam time CLK_HALF = 2ns;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_priv;
  logic [31:0] reg_wdata;
  logic        acc_done;
  logic [31:0] reg_rdata;
  logic        diag_armed;
  logic        diag_active;
  logic [2:0]  diag_mode;
  logic [2:0]  diag_sel;
  logic [1:0]  tag_sel_a;
  logic [3:0]  tag_sel_b;
  logic        flip_port_a;
  logic        flip_port_b;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // Bench reference state
  logic [3:0] m_key;
  logic [2:0] m_sel;
  logic [2:0] m_mode;
  logic       m_armed;
  logic       m_act;
  logic [2:0] m_amode;
  logic [2:0] m_asel;

  diag_ctl_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_priv    (reg_priv),
    .reg_wdata   (reg_wdata),
    .acc_done    (acc_done),
    .reg_rdata   (reg_rdata),
    .diag_armed  (diag_armed),
    .diag_active (diag_active),
    .diag_mode   (diag_mode),
    .diag_sel    (diag_sel),
    .tag_sel_a   (tag_sel_a),
    .tag_sel_b   (tag_sel_b),
    .flip_port_a (flip_port_a),
    .flip_port_b (flip_port_b)
  );

  initial clk = 1'b0;
  always #CLK_HALF clk = ~clk;

  function automatic logic ok_fields(input logic [3:0] k, input logic [2:0] m);
    return (k == 4'h5) && (m == 3'd5 || m == 3'd7);
  endfunction

  // Expected {tag_a[1:0], tag_b[3:0], flip_a, flip_b}
  function automatic logic [7:0] exp_dec(input logic a, input logic [2:0] m,
                                         input logic [2:0] s);
    logic [7:0] v;
    v = '0;
    if (a && m == 3'd5) begin
      if (s == 3'd0) v[6] = 1'b1;
      if (s == 3'd1) v[7] = 1'b1;
      if (s >= 3'd4) v[2 + (s - 3'd4)] = 1'b1;
    end
    if (a && m == 3'd7) begin
      if (s == 3'd0) v[1] = 1'b1;
      if (s == 3'd4) v[0] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [31:0] exp_rd();
    return {12'h000, m_key, 5'b0, m_sel, 5'b0, m_mode};
  endfunction

  task automatic compare(input string tag);
    logic [31:0] er;
    logic [7:0]  ed;
    logic [7:0]  ad;
    logic [2:0]  em;
    logic [2:0]  es;
    er = exp_rd();
    ed = exp_dec(m_act, m_amode, m_asel);
    ad = {tag_sel_a[0], tag_sel_a[1], tag_sel_b[0], tag_sel_b[1], tag_sel_b[2],
          tag_sel_b[3], flip_port_a, flip_port_b};
    // remap actual to expected layout: v[7]=a1 v[6]=a0 v[5..2]=b3..b0
    ad = {tag_sel_a[1], tag_sel_a[0], tag_sel_b[3], tag_sel_b[2], tag_sel_b[1],
          tag_sel_b[0], flip_port_a, flip_port_b};
    em = m_act ? m_amode : 3'd0;
    es = m_act ? m_asel  : 3'd0;
    n_checks++;
    if (reg_rdata !== er || diag_armed !== m_armed || diag_active !== m_act ||
        diag_mode !== em || diag_sel !== es || ad !== ed) begin
      n_fails++;
      $display("FAIL %s: rd=%h/%h armed=%b/%b act=%b/%b mode=%0d/%0d sel=%0d/%0d dec=%b/%b",
               tag, reg_rdata, er, diag_armed, m_armed, diag_active, m_act,
               diag_mode, em, diag_sel, es, ad, ed);
    end
  endtask

  // One clock: drive at falling edge, advance model, compare after rising edge
  task automatic step(input logic wr, input logic priv, input logic [31:0] wd,
                      input logic acc, input string tag);
    logic trig_ok;
    logic qual;
    logic fire;
    @(negedge clk);
    reg_wr    = wr;
    reg_priv  = priv;
    reg_wdata = wd;
    acc_done  = acc;
    trig_ok = wr && priv && wd[24] && ok_fields(wd[19:16], wd[2:0]);
    qual    = ok_fields(m_key, m_mode);
    fire    = m_armed && acc && qual;
    m_act   = fire;
    if (fire) begin
      m_amode = m_mode;
      m_asel  = m_sel;
    end
    if (trig_ok)            m_armed = 1'b1;
    else if (fire || !qual) m_armed = 1'b0;
    if (wr && priv) begin
      m_key  = wd[19:16];
      m_sel  = wd[10:8];
      m_mode = wd[2:0];
    end
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  function automatic logic [31:0] wv(input logic t, input logic [3:0] k,
                                     input logic [2:0] s, input logic [2:0] m);
    return {7'b0, t, 4'b0, k, 5'b0, s, 5'b0, m};
  endfunction

  initial begin
    #(CLK_HALF * 2 * 150000);
    n_fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_D1A6));
    rst_n = 1'b0; reg_wr = 0; reg_priv = 0; reg_wdata = '0; acc_done = 0;
    m_key = 4'hA; m_sel = 0; m_mode = 0; m_armed = 0; m_act = 0; m_amode = 0; m_asel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    compare("R1 reset");

    // R2 privileged write with every writable bit and the reserved bits set
    step(1, 1, 32'hFEFF_FFFF, 0, "R2 R4 field load, reserved read zero");
    // R3 unprivileged write, including a valid trigger
    step(1, 0, wv(1, 4'h5, 3'd4, 3'd5), 0, "R3 nonpriv ignored");
    step(0, 0, '0, 1, "R3 R11 no arm, access quiet");

    // R5 trigger with stale key but qualifying new values arms
    step(1, 1, wv(1, 4'h5, 3'd1, 3'd5), 0, "R5 arm with new key");
    step(0, 0, '0, 0, "R5 armed waits");
    step(0, 0, '0, 1, "R6 R7 fire port A buf1");
    step(0, 0, '0, 1, "R6 one access only");

    // R5 discarded triggers
    step(1, 1, wv(1, 4'h3, 3'd0, 3'd5), 0, "R5 bad key discarded");
    step(1, 1, wv(1, 4'h5, 3'd0, 3'd3), 0, "R5 reserved mode discarded");
    step(1, 1, wv(1, 4'h5, 3'd0, 3'd0), 1, "R5 mode zero discarded");

    // R7 port B buffers and reserved selector
    for (int s = 2; s < 8; s++) begin
      step(1, 1, wv(1, 4'h5, 3'(s), 3'd5), 0, "R7 arm tag");
      step(0, 0, '0, 1, "R7 tag select");
      step(0, 0, '0, 0, "R7 strobe ends");
    end

    // R8 ECC port decode including reserved selectors
    for (int s = 0; s < 8; s++) begin
      step(1, 1, wv(1, 4'h5, 3'(s), 3'd7), 0, "R8 arm ecc");
      step(0, 0, '0, 1, "R8 flip select");
    end

    // R10 trigger in the same cycle as a firing access
    step(1, 1, wv(1, 4'h5, 3'd4, 3'd7), 0, "R10 arm");
    step(1, 1, wv(1, 4'h5, 3'd0, 3'd7), 1, "R10 fire and re-arm");
    step(0, 0, '0, 1, "R10 second fire");
    step(0, 0, '0, 0, "R10 idle");

    // R9 key change while armed drops the arm
    step(1, 1, wv(1, 4'h5, 3'd0, 3'd5), 0, "R9 arm");
    step(1, 1, wv(0, 4'h0, 3'd0, 3'd5), 1, "R9 key cleared, access same cycle");
    step(0, 0, '0, 1, "R9 disarmed no fire");
    step(1, 1, wv(1, 4'h5, 3'd6, 3'd5), 0, "R9 rearm");
    step(1, 1, wv(0, 4'h5, 3'd6, 3'd2), 0, "R9 mode invalidated");
    step(1, 1, wv(0, 4'h5, 3'd6, 3'd5), 1, "R9 restored but dropped");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] k;
      logic [2:0] m;
      logic [31:0] w;
      logic        wr_r;
      logic        pr_r;
      logic        ac_r;
      k = ($urandom_range(0, 3) != 0) ? 4'h5 : 4'($urandom);
      case ($urandom_range(0, 3))
        0: m = 3'd5;
        1: m = 3'd7;
        2: m = 3'd0;
        default: m = 3'($urandom);
      endcase
      w = $urandom & 32'hFEF0_F8F8;
      w = w | wv(1'($urandom), k, 3'($urandom), m);
      wr_r = ($urandom_range(0, 2) == 0);
      pr_r = ($urandom_range(0, 4) != 0);
      ac_r = ($urandom_range(0, 2) == 0);
      step(wr_r, pr_r, w, ac_r, "R6 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule